// File: doc/BRIEF.md
# Delay-Slot Circular Accumulator

This block gathers weighted contributions aimed at a population of neurons and holds each one back until the timestep in which it is due. Every neuron owns a ring of delay slots. An incoming contribution carries a target neuron, a delay and a signed 32-bit fixed-point weight. It is added into the slot that sits `delay` positions ahead of the current ring pointer. Up to eight contributions arrive per beat, one per lane. Lanes that aim at the same neuron and slot in one beat are summed before the single update of that slot.

A timestep strobe starts a drain. For every neuron, in ascending order, the block presents the sum held in the slot under the pointer and then clears that slot. The pointer then moves on by one, wrapping around the ring. Input is refused for the whole drain. The storage packs two 32-bit sums into each 72-bit word: the even slot goes in the low half and the odd slot in the upper half, and the top eight bits stay zero.

Top module: `delay_ring_accum`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `delay_err` is 0, the ring pointer is 0 and every slot of every neuron holds zero.
- R2: An accepted lane with delay d (0 to 63) adds its weight into slot (pointer + d) mod 64 of its neuron. The contribution therefore appears in the drain started by the (d+1)-th accepted strobe after the beat.
- R3: Each completed drain advances the pointer by one modulo 64. A delay of 63 lands in the slot drained last of the next 64 drains, and slot indices wrap past 63 back to 0.
- R4: A lane with a delay of 64 or more is discarded. In the cycle after such a beat, `delay_err` is 1. Valid lanes of the same beat are still accumulated. In the cycle after a beat with no such lane, or after a cycle with no accepted beat, `delay_err` is 0.
- R5: All eight lanes are accumulated in one beat. Lanes that hit the same neuron and slot are summed together. Lanes that hit the two slots sharing one storage word do not disturb each other.
- R6: A strobe on `tick` while `in_ready` is 1 makes `out_valid` 1 from the next cycle for exactly NEURONS cycles. During those cycles `out_neuron` steps 0, 1, ... NEURONS-1 and `out_sum` carries that neuron's current-slot sum. `out_valid` then returns to 0.
- R7: A slot is zero after it has been drained. When the ring comes back to it, it carries only contributions made after that drain.
- R8: `in_ready` is 0 throughout a drain. Beats and `tick` strobes presented during a drain have no effect.
- R9: Sums wrap modulo 2^32 in two's complement. For example, 0x7FFFFFFF plus 1 gives 0x80000000, and 0xFFFFFFFF plus 2 gives 0x00000001.
- R10: Lanes whose bit in `in_lane_vld` is 0 have no effect. No lane has any effect in a cycle where `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A beat of contributions is presented |
| in_ready | output | 1 | Beats and strobes are taken (low while draining) |
| in_lane_vld | input | LANES | Per-lane enable within a beat |
| in_neuron | input | LANES x NID_W | Target neuron per lane |
| in_delay | input | LANES x 8 | Delay in timesteps per lane |
| in_weight | input | LANES x 32 | Signed fixed-point weight per lane |
| tick | input | 1 | Timestep-advance strobe |
| out_valid | output | 1 | A drained sum is presented |
| out_neuron | output | NID_W | Neuron whose sum is presented |
| out_sum | output | 32 | Drained slot sum |
| delay_err | output | 1 | Previous beat carried an out-of-range delay |

## Verification
A wrong pointer or slot calculation does not show up when the contribution goes in. It shows up only when a drain later delivers the sum one or more timesteps early or late. The error can therefore stay hidden for up to 64 drains. The bench compares every drained sum against a bench model, so such faults are caught at the first affected drain. A lost or doubled write from merging lanes, or from packing two values per word, shows up as a wrong `out_sum` in the same way. A slot that is not cleared shows up 64 drains later as a stale residue. A faulty drain sequencer shows up at once as a skipped or repeated `out_neuron`, a wrong drain length or a premature `in_ready`.

// File: rtl/dra_pkg.sv
package dra_pkg;

    localparam int WEIGHT_W      = 32;
    localparam int DELAY_W       = 8;
    localparam int WORD_W        = 72;
    localparam int VALS_PER_WORD = 2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } drain_state_e;

    // select one packed value out of a storage word
    function automatic logic [WEIGHT_W-1:0] word_half(input logic [WORD_W-1:0] w,
                                                      input logic             hi);
        return hi ? w[2*WEIGHT_W-1:WEIGHT_W] : w[WEIGHT_W-1:0];
    endfunction

endpackage

// File: rtl/dra_lane_merge.sv
module dra_lane_merge
    import dra_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int SLOTS  = 64,
    parameter int NID_W  = 3,
    parameter int SLOT_W = 6,
    localparam int KEY_W = NID_W + SLOT_W
) (
    input  logic                               take,
    input  logic [LANES-1:0]                   vld,
    input  logic [LANES-1:0][NID_W-1:0]        nid,
    input  logic [LANES-1:0][DELAY_W-1:0]      dly,
    input  logic [LANES-1:0][WEIGHT_W-1:0]     wt,
    input  logic [SLOT_W-1:0]                  ptr,
    output logic [LANES-1:0]                   upd_en,
    output logic [LANES-1:0][KEY_W-1:0]        upd_key,
    output logic [LANES-1:0][WEIGHT_W-1:0]     upd_add,
    output logic                               bad_any
);

    logic [LANES-1:0] live;

    // slot key per lane and range screening
    always_comb begin
        bad_any = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            upd_key[i] = {nid[i], ptr + dly[i][SLOT_W-1:0]};
            if ({1'b0, dly[i]} < (DELAY_W+1)'(SLOTS)) begin
                live[i] = take & vld[i];
            end else begin
                live[i] = 1'b0;
                bad_any = bad_any | (take & vld[i]);
            end
        end
    end

    // lowest lane of each key group carries the group sum
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            upd_en[i]  = live[i];
            upd_add[i] = '0;
            for (int j = 0; j < LANES; j++) begin
                if (live[j] && upd_key[j] == upd_key[i]) begin
                    if (j < i) upd_en[i] = 1'b0;
                    else       upd_add[i] = upd_add[i] + wt[j];
                end
            end
        end
    end

endmodule

// File: rtl/dra_slot_store.sv
module dra_slot_store
    import dra_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int NID_W   = 3,
    parameter int SLOT_W  = 6,
    localparam int KEY_W  = NID_W + SLOT_W,
    localparam int WADR_W = KEY_W - 1,
    localparam int WORDS  = 1 << WADR_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [LANES-1:0]               upd_en,
    input  logic [LANES-1:0][KEY_W-1:0]    upd_key,
    input  logic [LANES-1:0][WEIGHT_W-1:0] upd_add,
    input  logic                           clr_en,
    input  logic [KEY_W-1:0]               clr_key,
    output logic [WEIGHT_W-1:0]            clr_val
);

    logic [WORD_W-1:0] mem [WORDS];

    assign clr_val = word_half(mem[clr_key[KEY_W-1:1]], clr_key[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else begin
            if (clr_en) begin
                mem[clr_key[KEY_W-1:1]][clr_key[0]*WEIGHT_W +: WEIGHT_W] <= '0;
            end
            for (int i = 0; i < LANES; i++) begin
                if (upd_en[i]) begin
                    mem[upd_key[i][KEY_W-1:1]][upd_key[i][0]*WEIGHT_W +: WEIGHT_W] <=
                        word_half(mem[upd_key[i][KEY_W-1:1]], upd_key[i][0]) + upd_add[i];
                end
            end
        end
    end

endmodule

// File: rtl/dra_drain_ctrl.sv
module dra_drain_ctrl
    import dra_pkg::*;
#(
    parameter int NEURONS = 8,
    parameter int NID_W   = 3,
    parameter int SLOT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic              idle,
    output logic              draining,
    output logic [NID_W-1:0]  cnt,
    output logic [SLOT_W-1:0] ptr
);

    drain_state_e state;

    assign idle     = (state == ST_IDLE);
    assign draining = (state == ST_DRAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ptr   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (tick) begin
                        state <= ST_DRAIN;
                        cnt   <= '0;
                    end
                end
                ST_DRAIN: begin
                    if (cnt == NID_W'(NEURONS - 1)) begin
                        state <= ST_IDLE;
                        ptr   <= ptr + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/delay_ring_accum.sv
module delay_ring_accum
    import dra_pkg::*;
#(
    parameter int NEURONS = 8,
    parameter int SLOTS   = 64,
    parameter int LANES   = 8,
    localparam int NID_W  = $clog2(NEURONS),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int KEY_W  = NID_W + SLOT_W
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [LANES-1:0]                   in_lane_vld,
    input  logic [LANES-1:0][NID_W-1:0]        in_neuron,
    input  logic [LANES-1:0][DELAY_W-1:0]      in_delay,
    input  logic [LANES-1:0][WEIGHT_W-1:0]     in_weight,
    input  logic                               tick,
    output logic                               out_valid,
    output logic [NID_W-1:0]                   out_neuron,
    output logic [WEIGHT_W-1:0]                out_sum,
    output logic                               delay_err
);

    logic                           idle, draining, bad_any;
    logic [NID_W-1:0]               cnt;
    logic [SLOT_W-1:0]              ptr;
    logic [LANES-1:0]               upd_en;
    logic [LANES-1:0][KEY_W-1:0]    upd_key;
    logic [LANES-1:0][WEIGHT_W-1:0] upd_add;

    dra_drain_ctrl #(.NEURONS(NEURONS), .NID_W(NID_W), .SLOT_W(SLOT_W)) i_ctrl (
        .clk(clk), .rst(rst), .tick(tick),
        .idle(idle), .draining(draining), .cnt(cnt), .ptr(ptr)
    );

    dra_lane_merge #(.LANES(LANES), .SLOTS(SLOTS), .NID_W(NID_W), .SLOT_W(SLOT_W)) i_merge (
        .take(in_valid & idle), .vld(in_lane_vld), .nid(in_neuron), .dly(in_delay),
        .wt(in_weight), .ptr(ptr),
        .upd_en(upd_en), .upd_key(upd_key), .upd_add(upd_add), .bad_any(bad_any)
    );

    dra_slot_store #(.LANES(LANES), .NID_W(NID_W), .SLOT_W(SLOT_W)) i_store (
        .clk(clk), .rst(rst),
        .upd_en(upd_en), .upd_key(upd_key), .upd_add(upd_add),
        .clr_en(draining), .clr_key({cnt, ptr}), .clr_val(out_sum)
    );

    assign in_ready   = idle;
    assign out_valid  = draining;
    assign out_neuron = cnt;

    always_ff @(posedge clk) begin
        if (rst) delay_err <= 1'b0;
        else     delay_err <= bad_any;
    end

endmodule

// File: rtl/dra_checker.sv
module dra_checker
    import dra_pkg::*;
#(
    parameter int NEURONS = 8,
    parameter int SLOTS   = 64,
    parameter int LANES   = 8,
    parameter int NID_W   = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic                          in_ready,
    input logic [LANES-1:0]              in_lane_vld,
    input logic [LANES-1:0][DELAY_W-1:0] in_delay,
    input logic                          tick,
    input logic                          out_valid,
    input logic [NID_W-1:0]              out_neuron,
    input logic                          delay_err
);

    logic far_lane;
    always_comb begin
        far_lane = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (in_lane_vld[i] && {1'b0, in_delay[i]} >= (DELAY_W+1)'(SLOTS)) far_lane = 1'b1;
    end

    // R4
    bad_delay_flag_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && far_lane |=> delay_err);

    // R4
    quiet_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !delay_err);

    // R8
    drain_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R6
    drain_start_chk: assert property (@(posedge clk) disable iff (rst)
        tick && in_ready |=> out_valid && out_neuron == '0);

    // R6
    drain_order_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid) |-> out_neuron == NID_W'($past(out_neuron) + 1'b1));

    // R6
    drain_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_neuron) == NID_W'(NEURONS - 1));

endmodule

bind delay_ring_accum dra_checker #(
    .NEURONS(NEURONS), .SLOTS(SLOTS), .LANES(LANES), .NID_W(NID_W)
) i_dra_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_lane_vld(in_lane_vld), .in_delay(in_delay), .tick(tick),
    .out_valid(out_valid), .out_neuron(out_neuron), .delay_err(delay_err)
);

// File: tb/test_delay_ring_accum.sv
module test_delay_ring_accum;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int S  = 64;
    localparam int L  = 8;
    localparam int NW = 3;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic                  in_ready;
    logic [L-1:0]          in_lane_vld = '0;
    logic [L-1:0][NW-1:0]  in_neuron = '0;
    logic [L-1:0][7:0]     in_delay = '0;
    logic [L-1:0][31:0]    in_weight = '0;
    logic                  tick = 1'b0;
    logic                  out_valid;
    logic [NW-1:0]         out_neuron;
    logic [31:0]           out_sum;
    logic                  delay_err;

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 0;
    int          mptr    = 0;
    logic [31:0] exp_sum [N][S];

    always #(CLK_PERIOD/2) clk = ~clk;

    delay_ring_accum #(.NEURONS(N), .SLOTS(S), .LANES(L)) i_delay_ring_accum (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_lane_vld(in_lane_vld), .in_neuron(in_neuron), .in_delay(in_delay),
        .in_weight(in_weight), .tick(tick), .out_valid(out_valid),
        .out_neuron(out_neuron), .out_sum(out_sum), .delay_err(delay_err)
    );

    function automatic int target_slot(input int p, input int d);
        return (p + d) % S;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, expv);
        end
    endtask

    // one beat; model updated only for lanes the requirements say count
    task automatic beat(input bit v, input logic [L-1:0] m,
                        input logic [L-1:0][NW-1:0] nid,
                        input logic [L-1:0][7:0] dly,
                        input logic [L-1:0][31:0] wt);
        bit bad = 0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R8", "ready before beat", 32'(in_ready), 32'd1);
        in_valid = v; in_lane_vld = m; in_neuron = nid; in_delay = dly; in_weight = wt;
        if (v) begin
            for (int i = 0; i < L; i++) begin
                if (m[i] && dly[i] < 8'(S)) begin
                    int t = target_slot(mptr, int'(dly[i]));
                    exp_sum[nid[i]][t] = exp_sum[nid[i]][t] + wt[i];
                end else if (m[i]) begin
                    bad = 1;
                end
            end
        end
        @(negedge clk);
        chk(delay_err == bad, "R4", "delay_err", 32'(delay_err), 32'(bad));
        in_valid = 1'b0; in_lane_vld = '0;
    endtask

    // strobe and check a full drain; junk stimulus during drain must be ignored
    task automatic drain(input string tag, input bit junk);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = junk;
        if (junk) begin
            in_valid = 1'b1; in_lane_vld = '1; in_neuron = '0; in_delay = '0;
            in_weight = {L{32'd1}};
        end
        for (int n = 0; n < N; n++) begin
            chk(out_valid == 1'b1, "R6", "out_valid in drain", 32'(out_valid), 32'd1);
            chk(out_neuron == NW'(n), "R6", "out_neuron order", 32'(out_neuron), 32'(n));
            chk(out_sum == exp_sum[n][mptr], tag, "drained sum", out_sum, exp_sum[n][mptr]);
            chk(in_ready == 1'b0, "R8", "ready during drain", 32'(in_ready), 32'd0);
            exp_sum[n][mptr] = '0;
            @(negedge clk);
        end
        chk(out_valid == 1'b0, "R6", "out_valid after drain", 32'(out_valid), 32'd0);
        tick = 1'b0; in_valid = 1'b0; in_lane_vld = '0;
        mptr = (mptr + 1) % S;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [L-1:0][NW-1:0] nid;
        logic [L-1:0][7:0]    dly;
        logic [L-1:0][31:0]   wt;
        void'($urandom(32'h5EED_0042));
        for (int a = 0; a < N; a++) for (int b = 0; b < S; b++) exp_sum[a][b] = '0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R1", "out_valid", 32'(out_valid), 32'd0);
        chk(delay_err == 1'b0, "R1", "delay_err", 32'(delay_err), 32'd0);
        drain("R1", 0);

        // R2 distinct delays
        nid = '0; dly = '0; wt = '0;
        nid[0] = 3; dly[0] = 0; wt[0] = 32'd5;
        nid[1] = 5; dly[1] = 2; wt[1] = 32'd9;
        beat(1, 8'b0000_0011, nid, dly, wt);
        drain("R2", 0); drain("R2", 1); drain("R2", 0);

        // R5 all lanes on one slot, plus paired even/odd slots of one word
        for (int i = 0; i < L; i++) begin nid[i] = 2; dly[i] = 1; wt[i] = 32'(i + 1); end
        beat(1, '1, nid, dly, wt);
        for (int i = 0; i < L; i++) begin nid[i] = 6; dly[i] = 8'(i % 2); wt[i] = 32'(10 * i); end
        beat(1, '1, nid, dly, wt);
        drain("R5", 0); drain("R5", 0);

        // R9 wrap
        nid = '0; dly = '0;
        wt[0] = 32'h7FFF_FFFF; wt[1] = 32'd1; nid[2] = 1; wt[2] = 32'hFFFF_FFFF;
        nid[3] = 1; wt[3] = 32'd2;
        beat(1, 8'b0000_1111, nid, dly, wt);
        drain("R9", 0);

        // R4 out-of-range lanes mixed with good ones
        for (int i = 0; i < L; i++) begin nid[i] = NW'(i); dly[i] = 8'(i * 40); wt[i] = 32'(100 + i); end
        beat(1, '1, nid, dly, wt);
        beat(1, 8'b0000_0001, nid, dly, wt);
        drain("R4", 0);

        // R10 masked lanes and idle valid
        for (int i = 0; i < L; i++) begin nid[i] = 4; dly[i] = 0; wt[i] = 32'd77; end
        beat(0, '1, nid, dly, wt);
        beat(1, 8'b0000_0000, nid, dly, wt);
        beat(1, 8'b1000_0000, nid, dly, wt);
        drain("R10", 1);

        // R3 / R7 longest delay around the whole ring
        nid = '0; dly = '0; wt = '0;
        nid[0] = 7; dly[0] = 63; wt[0] = 32'hDEAD_0001;
        beat(1, 8'b0000_0001, nid, dly, wt);
        for (int k = 0; k < S; k++) drain("R3", k % 5 == 0);
        drain("R7", 0);

        // random phase, narrow neuron range some of the time for collisions
        for (int it = 0; it < 250; it++) begin
            bit narrow = ($urandom_range(0, 2) == 0);
            for (int i = 0; i < L; i++) begin
                nid[i] = NW'(narrow ? $urandom_range(0, 1) : $urandom_range(0, N - 1));
                dly[i] = 8'($urandom_range(0, 70));
                wt[i]  = $urandom;
            end
            beat($urandom_range(0, 7) != 0, L'($urandom), nid, dly, wt);
            if ($urandom_range(0, 2) == 0) drain("R2", $urandom_range(0, 1) == 1);
        end
        for (int k = 0; k < S; k++) drain("R7", 0);

        done = 1;
        summary();
    end

endmodule